// File: doc/BRIEF.md
# Host Event Status Register with Sticky Interrupt Flags

This block is a small status and control register on the slave processor side of a host bus link. It watches two active-low host inputs, the host bus reset line and the host power-down line, and turns each falling edge on them into a sticky flag. While either flag is set, a shared error interrupt request to the local processor stays asserted. Software acknowledges an event with a two-step handshake. It first reads the register while the flag is 1, then writes 0 to that flag's bit. A write alone, or a write of 1, leaves the flag untouched.

The same register gives a live, synchronized view of the host gate-A20 line in its top bit. It also holds one writable control bit. The control bit is driven out to logic elsewhere, which combines it with an enable held in another register. The power-down flag is also cleared by either of two host bus reset indications: the hardware reset and the software reset. All host inputs are asynchronous and pass through a two-stage synchronizer before they are used.

Top module: `hostev_status_reg`

## Requirements
- R1: Register bit 6 is the reset-event flag. It becomes 1 after the third rising clock edge following a falling edge on `host_rst_n_pin`. One physical edge sets it once, and a pin held low does not set it again.
- R2: Register bit 5 is the power-down-event flag. It becomes 1 after the third rising clock edge following a falling edge on `host_pwrdn_n_pin`.
- R3: `err_irq` is high exactly while bit 6 or bit 5 of the register is 1.
- R4: A flag is cleared only by a write (`cpu_wr`) carrying 0 in the flag's bit position, after a read (`cpu_rd`) made while the flag was 1 has armed it. A write with 1 in that position, or a write without a prior arming read, leaves the flag as it is. Any write ends the armed state, so a second write-0 needs a new read.
- R5: A new falling edge on a flag's pin cancels that flag's armed state. A set event that falls in the same cycle as a valid clear leaves the flag at 1, and the arm is cancelled.
- R6: While `bus_hw_rst` or `bus_sw_rst` is high at a rising edge, the power-down flag clears (unless a set event happens in that cycle). These inputs do not affect the reset-event flag.
- R7: Register bit 7 reads `host_a20_pin` through the two-stage synchronizer: a change shows after the second rising edge, independent of flags, writes or bus resets.
- R8: Bit 0 is a read/write control bit driven on `ctl_out`. Every write loads it from `cpu_wdata[0]`. Bits 4 to 1 always read 0.
- R9: After `rst_n` is released (host pins high), both flags, `ctl_out` and `err_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave-side clock |
| rst_n | input | 1 | Asynchronous active-low slave reset |
| host_rst_n_pin | input | 1 | Asynchronous active-low host bus reset line |
| host_pwrdn_n_pin | input | 1 | Asynchronous active-low host power-down line |
| host_a20_pin | input | 1 | Asynchronous gate-A20 line, monitored |
| bus_hw_rst | input | 1 | Synchronous host bus hardware reset indication |
| bus_sw_rst | input | 1 | Synchronous host bus software reset indication |
| cpu_rd | input | 1 | Register read strobe (arms set flags) |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid in the strobe cycle |
| err_irq | output | 1 | Shared error interrupt request, level |
| ctl_out | output | 1 | Value of the writable control bit |

## Verification
The hardest situation to reach from the ports is a valid clear landing in the very cycle in which a new pin edge sets the flag again. The write must hit the third rising edge after the pin drop, with the flag already set and armed. The directed stimulus arms the flag with a read, drops the pin and starts the write-0 exactly two clock periods later. It then shows that a further write-0 cannot clear the flag until a fresh read arms it. A long seeded random phase mixes pin toggles, reads, writes and bus resets, and every output is compared each cycle with a bench model.

// File: rtl/hostev_pkg.sv
package hostev_pkg;

  localparam int unsigned REG_W     = 8;
  localparam int unsigned NUM_FLAGS = 2;
  localparam int unsigned BIT_A20   = 7;
  localparam int unsigned BIT_RSTF  = 6;
  localparam int unsigned BIT_PDF   = 5;
  localparam int unsigned BIT_CTL   = 0;
  localparam int unsigned NUM_PINS  = NUM_FLAGS + 1;

  // Flag index 0: host reset event, index 1: power-down event
  function automatic int unsigned flag_pos(input int unsigned idx);
    return (idx == 0) ? BIT_RSTF : BIT_PDF;
  endfunction

  function automatic logic flag_bus_clearable(input int unsigned idx);
    return (idx == 1);
  endfunction

  // Set dominates any clear
  function automatic logic flag_next(input logic cur, input logic set_evt,
                                     input logic clr);
    return set_evt | (cur & ~clr);
  endfunction

  // Arm: established by a read of a set flag, removed by a set event,
  // by any clear and by any write
  function automatic logic arm_next(input logic arm, input logic cur,
                                    input logic set_evt, input logic clr,
                                    input logic wr, input logic rd);
    if (set_evt || clr || wr) return 1'b0;
    if (rd && cur) return 1'b1;
    return arm;
  endfunction

endpackage

// File: rtl/hostev_sync.sv
module hostev_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RESET_VAL;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= RESET_VAL;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/hostev_fall_det.sv
module hostev_fall_det #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] fall
);

  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= lvl;
  end

  assign fall = prev_q & ~lvl;

endmodule

// File: rtl/hostev_sticky_flag.sv
module hostev_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic bus_clr,
  input  logic rd_stb,
  input  logic wr_stb,
  input  logic wr_bit,
  output logic flag_q,
  output logic arm_q,
  output logic sw_clr
);

  import hostev_pkg::*;

  logic clr;

  assign sw_clr = wr_stb & ~wr_bit & arm_q;
  assign clr    = sw_clr | bus_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_next(flag_q, set_evt, clr);
      arm_q  <= arm_next(arm_q, flag_q, set_evt, clr, wr_stb, rd_stb);
    end
  end

endmodule

// File: rtl/hostev_status_reg.sv
module hostev_status_reg #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_rst_n_pin,
  input  logic       host_pwrdn_n_pin,
  input  logic       host_a20_pin,
  input  logic       bus_hw_rst,
  input  logic       bus_sw_rst,
  input  logic       cpu_rd,
  input  logic       cpu_wr,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  output logic       err_irq,
  output logic       ctl_out
);

  import hostev_pkg::*;

  logic [NUM_PINS-1:0]  pin_raw;
  logic [NUM_PINS-1:0]  pin_sync;
  logic [NUM_FLAGS-1:0] fall_evt;
  logic [NUM_FLAGS-1:0] flag_vec;
  logic [NUM_FLAGS-1:0] arm_vec;
  logic [NUM_FLAGS-1:0] sw_clr_vec;
  logic                 bus_clr_any;
  logic                 a20_sync;
  logic                 ctl_q;
  logic [3:0]           unused_wbits;

  assign pin_raw     = {host_a20_pin, host_pwrdn_n_pin, host_rst_n_pin};
  assign bus_clr_any = bus_hw_rst | bus_sw_rst;
  assign unused_wbits = cpu_wdata[4:1];

  hostev_sync #(
    .WIDTH    (NUM_PINS),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL('1)
  ) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_raw),
    .q    (pin_sync)
  );

  assign a20_sync = pin_sync[NUM_PINS-1];

  hostev_fall_det #(
    .WIDTH(NUM_FLAGS)
  ) i_fall (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (pin_sync[NUM_FLAGS-1:0]),
    .fall (fall_evt)
  );

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    localparam int unsigned POS = flag_pos(i);
    logic bus_clr_i;
    if (flag_bus_clearable(i)) begin : g_busclr
      assign bus_clr_i = bus_clr_any;
    end else begin : g_nobusclr
      assign bus_clr_i = 1'b0;
    end

    hostev_sticky_flag i_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_evt(fall_evt[i]),
      .bus_clr(bus_clr_i),
      .rd_stb (cpu_rd),
      .wr_stb (cpu_wr),
      .wr_bit (cpu_wdata[POS]),
      .flag_q (flag_vec[i]),
      .arm_q  (arm_vec[i]),
      .sw_clr (sw_clr_vec[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= 1'b0;
    else if (cpu_wr) ctl_q <= cpu_wdata[BIT_CTL];
  end

  always_comb begin
    cpu_rdata = '0;
    cpu_rdata[BIT_A20] = a20_sync;
    for (int unsigned i = 0; i < NUM_FLAGS; i++) begin
      cpu_rdata[flag_pos(i)] = flag_vec[i];
    end
    cpu_rdata[BIT_CTL] = ctl_q;
  end

  assign err_irq = |flag_vec;
  assign ctl_out = ctl_q;

endmodule

// File: rtl/hostev_status_checker.sv
module hostev_status_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_rd,
  input logic       cpu_wr,
  input logic [7:0] cpu_wdata,
  input logic       bus_hw_rst,
  input logic       bus_sw_rst,
  input logic [1:0] fall_evt,
  input logic [1:0] flag_q,
  input logic [1:0] arm_q,
  input logic [1:0] sw_clr,
  input logic       err_irq,
  input logic       ctl_out
);

  logic unused_chk;
  assign unused_chk = ^cpu_wdata[4:1];

  assert_rst_flag_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[0]) |-> $past(fall_evt[0]));

  assert_pd_flag_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[1]) |-> $past(fall_evt[1]));

  assert_irq_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_irq) |-> $past(fall_evt != 2'b00));

  assert_irq_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (err_irq && !cpu_wr && !bus_hw_rst && !bus_sw_rst) |=> err_irq);

  assert_rst_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q[0]) |-> $past(sw_clr[0] && !cpu_wdata[6] && cpu_wr));

  assert_write_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_wdata[6] && flag_q[0]) |=> flag_q[0]);

  assert_arm_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !cpu_wr && flag_q[0] && !fall_evt[0]) |=> arm_q[0]);

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt[0] |=> (flag_q[0] && !arm_q[0]));

  assert_bus_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_hw_rst || bus_sw_rst) && !fall_evt[1]) |=> !flag_q[1]);

  assert_ctl_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |=> (ctl_out == $past(cpu_wdata[0])));

endmodule

bind hostev_status_reg hostev_status_checker i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_rd    (cpu_rd),
  .cpu_wr    (cpu_wr),
  .cpu_wdata (cpu_wdata),
  .bus_hw_rst(bus_hw_rst),
  .bus_sw_rst(bus_sw_rst),
  .fall_evt  (fall_evt),
  .flag_q    (flag_vec),
  .arm_q     (arm_vec),
  .sw_clr    (sw_clr_vec),
  .err_irq   (err_irq),
  .ctl_out   (ctl_out)
);

// File: tb/test_hostev_status_reg.sv
module test_hostev_status_reg;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_rst_n_pin = 1'b1;
  logic       host_pwrdn_n_pin = 1'b1;
  logic       host_a20_pin = 1'b1;
  logic       bus_hw_rst = 1'b0;
  logic       bus_sw_rst = 1'b0;
  logic       cpu_rd = 1'b0;
  logic       cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic       err_irq;
  logic       ctl_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit cont_en = 1'b0;

  always #2 clk = ~clk;

  hostev_status_reg i_hostev_status_reg (
    .clk             (clk),
    .rst_n           (rst_n),
    .host_rst_n_pin  (host_rst_n_pin),
    .host_pwrdn_n_pin(host_pwrdn_n_pin),
    .host_a20_pin    (host_a20_pin),
    .bus_hw_rst      (bus_hw_rst),
    .bus_sw_rst      (bus_sw_rst),
    .cpu_rd          (cpu_rd),
    .cpu_wr          (cpu_wr),
    .cpu_wdata       (cpu_wdata),
    .cpu_rdata       (cpu_rdata),
    .err_irq         (err_irq),
    .ctl_out         (ctl_out)
  );

  // ---------------- reference model, written from the requirements
  logic [2:0] hist1, hist2, hist3;  // pin samples, 1..3 edges old
  logic [1:0] m_flag, m_arm;
  logic       m_ctl;

  function automatic int unsigned pos_of(input int idx);
    case (idx)
      0:       return 6;
      default: return 5;
    endcase
  endfunction

  function automatic logic model_flag(input logic f, input logic edge_seen,
                                      input logic cleared);
    if (edge_seen) return 1'b1;
    if (cleared)   return 1'b0;
    return f;
  endfunction

  function automatic logic model_arm(input logic a, input logic f,
                                     input logic edge_seen, input logic cleared,
                                     input logic wr, input logic rd);
    logic res;
    res = a;
    if (rd && f) res = 1'b1;
    if (wr || cleared || edge_seen) res = 1'b0;
    return res;
  endfunction

  function automatic logic [7:0] model_rdata();
    logic [7:0] v;
    v = 8'h00;
    v[7] = hist2[2];
    v[6] = m_flag[0];
    v[5] = m_flag[1];
    v[0] = m_ctl;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist1 <= 3'b111; hist2 <= 3'b111; hist3 <= 3'b111;
      m_flag <= 2'b00; m_arm <= 2'b00; m_ctl <= 1'b0;
    end else begin
      hist1 <= {host_a20_pin, host_pwrdn_n_pin, host_rst_n_pin};
      hist2 <= hist1;
      hist3 <= hist2;
      for (int i = 0; i < 2; i++) begin
        logic edge_seen, cleared;
        edge_seen = hist3[i] && !hist2[i];
        cleared = (cpu_wr && !cpu_wdata[pos_of(i)] && m_arm[i]) ||
                  (i == 1 && (bus_hw_rst || bus_sw_rst));
        m_flag[i] <= model_flag(m_flag[i], edge_seen, cleared);
        m_arm[i]  <= model_arm(m_arm[i], m_flag[i], edge_seen, cleared,
                               cpu_wr, cpu_rd);
      end
      if (cpu_wr) m_ctl <= cpu_wdata[0];
    end
  end

  // ---------------- checking
  task automatic chk(input string req, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at cycle %0d",
               req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (cont_en) begin
      logic [7:0] e;
      e = model_rdata();
      chk("R1 reset flag bit", {7'd0, cpu_rdata[6]}, {7'd0, e[6]});
      chk("R2 power-down flag bit", {7'd0, cpu_rdata[5]}, {7'd0, e[5]});
      chk("R3 err_irq", {7'd0, err_irq}, {7'd0, e[6] | e[5]});
      chk("R7 a20 monitor", {7'd0, cpu_rdata[7]}, {7'd0, e[7]});
      chk("R8 ctl and zero bits", {3'd0, cpu_rdata[4:0]}, {3'd0, e[4:0]});
      chk("R8 ctl_out", {7'd0, ctl_out}, {7'd0, e[0]});
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpu_read();
    cpu_rd = 1'b1; tick(1); cpu_rd = 1'b0;
  endtask

  task automatic cpu_write(input logic [7:0] d);
    cpu_wr = 1'b1; cpu_wdata = d; tick(1); cpu_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    tick(5);
    rst_n = 1'b1;
    tick(3);
    // R9 reset state (a20 pin high, so bit 7 reads 1)
    chk("R9 reset rdata", cpu_rdata, 8'h80);
    chk("R9 reset err_irq", {7'd0, err_irq}, 8'h00);
    chk("R9 reset ctl_out", {7'd0, ctl_out}, 8'h00);
    cont_en = 1'b1;

    // R1 latency and single set
    host_rst_n_pin = 1'b0;
    tick(2); chk("R1 not before third edge", {7'd0, cpu_rdata[6]}, 8'h00);
    tick(1); chk("R1 set on third edge", {7'd0, cpu_rdata[6]}, 8'h01);
    chk("R3 irq with reset flag", {7'd0, err_irq}, 8'h01);

    // R4 clear handshake
    cpu_write(8'h00);
    chk("R4 write0 without read", {7'd0, cpu_rdata[6]}, 8'h01);
    cpu_read(); cpu_write(8'h40);
    chk("R4 write1 no effect", {7'd0, cpu_rdata[6]}, 8'h01);
    cpu_write(8'h00);
    chk("R4 arm consumed by write", {7'd0, cpu_rdata[6]}, 8'h01);
    cpu_read(); cpu_write(8'h00);
    chk("R4 read then write0 clears", {7'd0, cpu_rdata[6]}, 8'h00);
    chk("R3 irq drops", {7'd0, err_irq}, 8'h00);

    // R5 new edge cancels arm
    host_rst_n_pin = 1'b1; tick(3);
    host_rst_n_pin = 1'b0; tick(3);
    host_rst_n_pin = 1'b1; tick(3);
    cpu_read();
    host_rst_n_pin = 1'b0; tick(3);
    cpu_write(8'h00);
    chk("R5 edge cancels arm", {7'd0, cpu_rdata[6]}, 8'h01);

    // R5 set and valid clear in the same cycle
    host_rst_n_pin = 1'b1; tick(3);
    cpu_read();
    host_rst_n_pin = 1'b0; tick(2);
    cpu_write(8'h00);
    chk("R5 set wins over clear", {7'd0, cpu_rdata[6]}, 8'h01);
    cpu_write(8'h00);
    chk("R5 arm gone after collision", {7'd0, cpu_rdata[6]}, 8'h01);
    cpu_read(); cpu_write(8'h00);
    chk("R5 later clear works", {7'd0, cpu_rdata[6]}, 8'h00);

    // R2 and R6
    host_pwrdn_n_pin = 1'b0;
    tick(2); chk("R2 not before third edge", {7'd0, cpu_rdata[5]}, 8'h00);
    tick(1); chk("R2 set on third edge", {7'd0, cpu_rdata[5]}, 8'h01);
    bus_sw_rst = 1'b1; tick(1); bus_sw_rst = 1'b0;
    chk("R6 sw reset clears pd flag", {7'd0, cpu_rdata[5]}, 8'h00);
    host_pwrdn_n_pin = 1'b1; tick(3); host_pwrdn_n_pin = 1'b0; tick(3);
    host_rst_n_pin = 1'b1; tick(3); host_rst_n_pin = 1'b0; tick(3);
    chk("R6 both flags set", cpu_rdata & 8'h60, 8'h60);
    bus_hw_rst = 1'b1; tick(1); bus_hw_rst = 1'b0;
    chk("R6 hw reset clears only pd flag", cpu_rdata & 8'h60, 8'h40);
    cpu_read(); cpu_write(8'h00);

    // R7 a20 monitor
    host_a20_pin = 1'b0;
    tick(1); chk("R7 a20 after one edge", {7'd0, cpu_rdata[7]}, 8'h01);
    tick(1); chk("R7 a20 after two edges", {7'd0, cpu_rdata[7]}, 8'h00);
    host_a20_pin = 1'b1; tick(2);
    chk("R7 a20 back high", {7'd0, cpu_rdata[7]}, 8'h01);

    // R8 control bit
    cpu_write(8'h1F);
    chk("R8 ctl set, bits 4:1 zero", cpu_rdata & 8'h1F, 8'h01);
    chk("R8 ctl_out high", {7'd0, ctl_out}, 8'h01);
    cpu_write(8'h00);
    chk("R8 ctl cleared", {7'd0, ctl_out}, 8'h00);

    // seeded random phase, checked by the model each cycle
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(15) == 0) host_rst_n_pin = ~host_rst_n_pin;
      if ($urandom_range(15) == 0) host_pwrdn_n_pin = ~host_pwrdn_n_pin;
      if ($urandom_range(7) == 0)  host_a20_pin = ~host_a20_pin;
      bus_hw_rst = ($urandom_range(39) == 0);
      bus_sw_rst = ($urandom_range(39) == 0);
      cpu_rd = ($urandom_range(2) == 0);
      cpu_wr = ($urandom_range(3) == 0);
      cpu_wdata = 8'($urandom);
      tick(1);
    end
    cpu_rd = 1'b0; cpu_wr = 1'b0; bus_hw_rst = 1'b0; bus_sw_rst = 1'b0;
    tick(4);
    finish_run();
  end

endmodule